// File: doc/BRIEF.md
# Translation Cache with Global-Entry Retention

This block keeps a small, fully associative set of recent page translations in front of the page-table walker. A lookup presents a 20-bit virtual page number. In the same cycle the block reports a hit, the 20-bit physical frame number and the 12 attribute bits that were cached with it. When a lookup misses, the walker fetches the leaf table entry and writes it back through the refill port. The tables in memory are only consulted on a miss.

Software keeps the cache coherent with the tables in memory in two ways. A single-page invalidation removes the translation for one virtual page. This is used after a directory or table entry is changed, and it removes the entry even when the entry is global. A flush is used when the directory base register is reloaded. It drops every translation except those whose global attribute (attribute bit 8) is set.

A refill that names a page already cached overwrites that entry in place. Otherwise the refill goes to the lowest-numbered free slot. When every slot is full, a round-robin pointer picks the slot to replace.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and the round-robin pointer is at slot 0.
- R2: A lookup is combinational. `lk_hit` is 1 in the same cycle that `lk_vpn` equals the tag of a valid entry, and `lk_pfn`/`lk_attr` then carry that entry's frame and attributes. On a miss both outputs read zero.
- R3: A refill becomes visible to lookups from the cycle after `fill_en`. If the refill page is already held in a valid entry, that entry is overwritten, so at most one entry ever matches a page.
- R4: A refill for a page that is not cached goes to the lowest-indexed invalid entry when one exists.
- R5: When all entries are valid and the refill page is not cached, the refill replaces the entry at the round-robin pointer. The pointer then advances by one and wraps from DEPTH-1 to 0. It does not move on any other refill.
- R6: `flush_en` invalidates every entry whose attribute bit 8 is 0. Entries with bit 8 set stay valid and keep their contents.
- R7: `inv_en` invalidates the valid entry whose tag equals `inv_vpn`, whether or not its global bit is set. All other entries are untouched.
- R8: When a flush or an invalidation falls in the same cycle as a refill, the refill is applied last. The new entry is valid in the next cycle even if it is non-global or has the invalidated page. The slot choice uses the valid bits as they stood before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_hit | output | 1 | Lookup found a valid matching entry |
| lk_pfn | output | 20 | Physical frame number of the hit, zero on miss |
| lk_attr | output | 12 | Attribute bits of the hit (bit 8 = global), zero on miss |
| fill_en | input | 1 | Write a walker result into the cache |
| fill_vpn | input | 20 | Virtual page number of the refill |
| fill_pfn | input | 20 | Physical frame number of the refill |
| fill_attr | input | 12 | Attribute bits of the refill |
| inv_en | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Virtual page number to invalidate |
| flush_en | input | 1 | Base-register reload: drop all non-global entries |

## Verification
Both a flush and a single-page invalidation can coincide with a refill. They can also coincide with each other, and with a refill of a page that is already cached or of a full cache. The bench forces these coincidences on purpose in directed steps. A long pseudo-random sequence then covers them as well, drawing from a pool of six pages over a four-slot configuration so that tags collide and the cache fills often. After every cycle the bench sweeps the whole pool through the lookup port. Each result is compared with a model built from the ordering rule: the pre-cycle valid bits pick the slot, flush and invalidation clear entries, and the refill lands last.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   localparam int unsigned XL_VPN_W  = 20;
   localparam int unsigned XL_PFN_W  = 20;
   localparam int unsigned XL_ATTR_W = 12;
   localparam int unsigned XL_GBIT   = 8;

   typedef enum logic [1:0] {
      SLOT_SAME = 2'd0,
      SLOT_FREE = 2'd1,
      SLOT_RR   = 2'd2
   } slot_src_e;
endpackage

// File: rtl/xlat_entry.sv
module xlat_entry #(
   parameter int unsigned VPN_W  = 20,
   parameter int unsigned PFN_W  = 20,
   parameter int unsigned ATTR_W = 12,
   parameter int unsigned GBIT   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [VPN_W-1:0]  inv_vpn,
   input  logic              inv_en,
   input  logic              flush_en,
   input  logic              wr_en,
   input  logic [PFN_W-1:0]  wr_pfn,
   input  logic [ATTR_W-1:0] wr_attr,
   output logic              valid_o,
   output logic              lk_match_o,
   output logic              fill_match_o,
   output logic [PFN_W-1:0]  pfn_o,
   output logic [ATTR_W-1:0] attr_o
);
   logic              valid_q;
   logic [VPN_W-1:0]  tag_q;
   logic [PFN_W-1:0]  pfn_q;
   logic [ATTR_W-1:0] attr_q;
   logic              inv_hit;
   logic              drop_local;

   assign inv_hit    = inv_en && (tag_q == inv_vpn);
   assign drop_local = flush_en && !attr_q[GBIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         tag_q   <= '0;
         pfn_q   <= '0;
         attr_q  <= '0;
      end else if (wr_en) begin
         valid_q <= 1'b1;
         tag_q   <= fill_vpn;
         pfn_q   <= wr_pfn;
         attr_q  <= wr_attr;
      end else if (drop_local || inv_hit) begin
         valid_q <= 1'b0;
      end
   end

   assign valid_o      = valid_q;
   assign lk_match_o   = valid_q && (tag_q == lk_vpn);
   assign fill_match_o = valid_q && (tag_q == fill_vpn);
   assign pfn_o        = pfn_q;
   assign attr_o       = attr_q;

   // R6: a local entry does not outlive a flush
   a_r6_flush_drops_local: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_en && !wr_en && !attr_q[GBIT]) |=> !valid_q);
   // R6: a global entry survives a flush with contents intact
   a_r6_global_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_en && !wr_en && !inv_hit && valid_q && attr_q[GBIT])
         |=> (valid_q && $stable(tag_q) && $stable(pfn_q)));
   // R7: invalidation removes a matching entry even when global
   a_r7_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_en && !wr_en && valid_q && tag_q == inv_vpn) |=> !valid_q);
   // R8: a write always lands, whatever else happens that cycle
   a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (valid_q && tag_q == $past(fill_vpn)));
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
   import xlat_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fill_en,
   input  logic [DEPTH-1:0] valid_vec,
   input  logic [DEPTH-1:0] fmatch_vec,
   output logic [DEPTH-1:0] wr_vec
);
   logic [IW-1:0] ptr_q;
   logic [IW-1:0] slot;
   slot_src_e     src;

   always_comb begin
      src  = SLOT_RR;
      slot = ptr_q;
      if (|fmatch_vec) begin
         src = SLOT_SAME;
         for (int i = DEPTH - 1; i >= 0; i--)
            if (fmatch_vec[i]) slot = IW'(i);
      end else if (!(&valid_vec)) begin
         src = SLOT_FREE;
         for (int i = DEPTH - 1; i >= 0; i--)
            if (!valid_vec[i]) slot = IW'(i);
      end
   end

   always_comb begin
      wr_vec = '0;
      if (fill_en) wr_vec[slot] = 1'b1;
   end

   generate
      if ((1 << IW) == DEPTH) begin : g_pow2_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)                          ptr_q <= '0;
            else if (fill_en && src == SLOT_RR)  ptr_q <= ptr_q + 1'b1;
         end
      end else begin : g_cmp_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)                          ptr_q <= '0;
            else if (fill_en && src == SLOT_RR)
               ptr_q <= (ptr_q == IW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
         end
      end
   endgenerate

   // R5: pointer steps by one, with wrap, only when it chose the slot
   a_r5_rr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && src == SLOT_RR) |=>
         (ptr_q == (($past(ptr_q) == IW'(DEPTH - 1)) ? '0 : $past(ptr_q) + 1'b1)));
   a_r5_rr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(fill_en && src == SLOT_RR) |=> $stable(ptr_q));
   // R4: exactly one slot written per refill, and only a free one when any is free
   a_r4_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |-> ($countones(wr_vec) == 1));
   a_r4_free_first: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && fmatch_vec == '0 && !(&valid_vec)) |-> ((wr_vec & valid_vec) == '0));
endmodule

// File: rtl/xlat_rdmux.sv
module xlat_rdmux #(
   parameter int unsigned N = 8,
   parameter int unsigned W = 32
) (
   input  logic [N-1:0]        sel,
   input  logic [N-1:0][W-1:0] din,
   output logic [W-1:0]        dout
);
   always_comb begin
      dout = '0;
      for (int i = 0; i < N; i++)
         dout = dout | (din[i] & {W{sel[i]}});
   end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned VPN_W  = XL_VPN_W,
   parameter int unsigned PFN_W  = XL_PFN_W,
   parameter int unsigned ATTR_W = XL_ATTR_W,
   parameter int unsigned GBIT   = XL_GBIT,
   localparam int unsigned DW    = PFN_W + ATTR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VPN_W-1:0]  lk_vpn,
   output logic              lk_hit,
   output logic [PFN_W-1:0]  lk_pfn,
   output logic [ATTR_W-1:0] lk_attr,
   input  logic              fill_en,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PFN_W-1:0]  fill_pfn,
   input  logic [ATTR_W-1:0] fill_attr,
   input  logic              inv_en,
   input  logic [VPN_W-1:0]  inv_vpn,
   input  logic              flush_en
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("xlat_cache: DEPTH must be at least 2");
      end
      if (GBIT >= ATTR_W) begin : g_bad_gbit
         $error("xlat_cache: GBIT must lie inside the attribute field");
      end
   endgenerate

   logic [DEPTH-1:0]         valid_vec;
   logic [DEPTH-1:0]         hit_vec;
   logic [DEPTH-1:0]         fmatch_vec;
   logic [DEPTH-1:0]         wr_vec;
   logic [DEPTH-1:0][DW-1:0] data_arr;
   logic [DW-1:0]            data_sel;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         logic [PFN_W-1:0]  e_pfn;
         logic [ATTR_W-1:0] e_attr;
         xlat_entry #(
            .VPN_W(VPN_W), .PFN_W(PFN_W), .ATTR_W(ATTR_W), .GBIT(GBIT)
         ) u_ent (
            .clk          (clk),
            .rst_n        (rst_n),
            .lk_vpn       (lk_vpn),
            .fill_vpn     (fill_vpn),
            .inv_vpn      (inv_vpn),
            .inv_en       (inv_en),
            .flush_en     (flush_en),
            .wr_en        (wr_vec[g]),
            .wr_pfn       (fill_pfn),
            .wr_attr      (fill_attr),
            .valid_o      (valid_vec[g]),
            .lk_match_o   (hit_vec[g]),
            .fill_match_o (fmatch_vec[g]),
            .pfn_o        (e_pfn),
            .attr_o       (e_attr)
         );
         assign data_arr[g] = {e_pfn, e_attr};
      end
   endgenerate

   xlat_victim #(.DEPTH(DEPTH)) u_vict (
      .clk        (clk),
      .rst_n      (rst_n),
      .fill_en    (fill_en),
      .valid_vec  (valid_vec),
      .fmatch_vec (fmatch_vec),
      .wr_vec     (wr_vec)
   );

   xlat_rdmux #(.N(DEPTH), .W(DW)) u_mux (
      .sel  (hit_vec),
      .din  (data_arr),
      .dout (data_sel)
   );

   assign lk_hit  = |hit_vec;
   assign lk_pfn  = data_sel[DW-1:ATTR_W];
   assign lk_attr = data_sel[ATTR_W-1:0];

   // R3: refill deduplication keeps every page in at most one slot
   a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec) && $onehot0(fmatch_vec));
   // R2: a miss drives zero data
   a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_pfn == '0 && lk_attr == '0));
   // R1: first cycle out of reset holds no valid entry
   a_r1_reset_empty: assert property (@(posedge clk)
      !rst_n |=> (valid_vec == '0));
endmodule

// File: tb/sim_xlat_cache.sv
`timescale 1ns/1ps
module sim_xlat_cache;
   localparam int D  = 4;
   localparam int NP = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] lk_vpn = '0;
   logic        lk_hit;
   logic [19:0] lk_pfn;
   logic [11:0] lk_attr;
   logic        fill_en = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [19:0] fill_pfn = '0;
   logic [11:0] fill_attr = '0;
   logic        inv_en = 1'b0;
   logic [19:0] inv_vpn = '0;
   logic        flush_en = 1'b0;

   always #4 clk = ~clk;

   xlat_cache #(.DEPTH(D)) u0 (
      .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
      .lk_pfn(lk_pfn), .lk_attr(lk_attr), .fill_en(fill_en),
      .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_attr(fill_attr),
      .inv_en(inv_en), .inv_vpn(inv_vpn), .flush_en(flush_en)
   );

   int n_chk = 0;
   int n_bad = 0;

   bit          m_v [D];
   logic [19:0] m_t [D];
   logic [19:0] m_p [D];
   logic [11:0] m_a [D];
   int          m_ptr;

   function automatic logic [19:0] pool(int k);
      return 20'hA5000 ^ (20'(k) * 20'h01111);
   endfunction

   task automatic report_and_end();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // sweep every pool page through the lookup port, compare with the model
   task automatic sweep(string tag);
      for (int k = 0; k < NP; k++) begin
         bit          eh = 0;
         logic [19:0] ep = '0;
         logic [11:0] ea = '0;
         for (int i = 0; i < D; i++)
            if (m_v[i] && m_t[i] == pool(k)) begin
               eh = 1; ep = m_p[i]; ea = m_a[i];
            end
         lk_vpn = pool(k);
         #1;
         n_chk++;
         if (lk_hit !== eh || lk_pfn !== ep || lk_attr !== ea) begin
            n_bad++;
            $display("FAIL %s page %0d: got hit=%0b pfn=%h attr=%h, expected hit=%0b pfn=%h attr=%h",
                     tag, k, lk_hit, lk_pfn, lk_attr, eh, ep, ea);
         end
      end
   endtask

   // one clock of operations; model applies R4/R5 slot choice, R6/R7 clears, R8 ordering
   task automatic step(bit f, int fk, logic [19:0] fp, logic [11:0] fa,
                       bit iv, int ik, bit fl, string tag);
      int  slot = -1;
      bit  pre_v [D];
      @(negedge clk);
      fill_en = f; fill_vpn = pool(fk); fill_pfn = fp; fill_attr = fa;
      inv_en = iv; inv_vpn = pool(ik); flush_en = fl;
      for (int i = 0; i < D; i++) pre_v[i] = m_v[i];
      if (f) begin
         for (int i = D - 1; i >= 0; i--)
            if (pre_v[i] && m_t[i] == pool(fk)) slot = i;
         if (slot < 0)
            for (int i = D - 1; i >= 0; i--)
               if (!pre_v[i]) slot = i;
         if (slot < 0) begin
            slot = m_ptr;
            m_ptr = (m_ptr + 1) % D;
         end
      end
      for (int i = 0; i < D; i++) begin
         if (i == slot) begin
            m_v[i] = 1; m_t[i] = pool(fk); m_p[i] = fp; m_a[i] = fa;
         end else if ((fl && !m_a[i][8]) || (iv && m_t[i] == pool(ik))) begin
            m_v[i] = 0;
         end
      end
      @(posedge clk);
      #1;
      fill_en = 0; inv_en = 0; flush_en = 0;
      sweep(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      report_and_end();
   end

   initial begin
      logic [31:0] r;
      logic [19:0] pc;
      for (int i = 0; i < D; i++) begin
         m_v[i] = 0; m_t[i] = '0; m_p[i] = '0; m_a[i] = '0;
      end
      m_ptr = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      sweep("R1 reset empty");

      // R2/R4: fill into free slots, lowest index first; hit data returned
      step(1, 0, 20'h11111, 12'h001, 0, 0, 0, "R2 R4 first fill");
      step(1, 1, 20'h22222, 12'h103, 0, 0, 0, "R4 second fill global");
      step(1, 2, 20'h33333, 12'h007, 0, 0, 0, "R4 third fill");
      // R3: refill of a cached page overwrites in place
      step(1, 1, 20'h2BBBB, 12'h105, 0, 0, 0, "R3 refill same page");
      step(1, 3, 20'h44444, 12'h003, 0, 0, 0, "R4 fill last free");
      // R5: full cache, round robin replaces slot 0 then slot 1
      step(1, 4, 20'h55555, 12'h001, 0, 0, 0, "R5 rr evict slot0");
      step(1, 5, 20'h66666, 12'h101, 0, 0, 0, "R5 rr evict slot1");
      // R6: flush keeps only the global entries
      step(0, 0, '0, '0, 0, 0, 1, "R6 flush spares global");
      // R7: invalidation removes a global entry
      step(0, 0, '0, '0, 1, 5, 0, "R7 inv global page");
      // R8: flush and fill in one cycle, new local entry survives
      step(1, 2, 20'h77777, 12'h002, 0, 0, 1, "R8 flush plus fill");
      // R8: invalidate and fill of the same page, fill wins
      step(1, 2, 20'h78787, 12'h004, 1, 2, 0, "R8 inv plus fill same page");
      step(1, 0, 20'h79797, 12'h100, 1, 2, 1, "R8 all three together");

      // pseudo-random sequence over the small pool
      r = 32'h1ACE_B00C;
      pc = 20'h80000;
      for (int n = 0; n < 400; n++) begin
         r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
         r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
         r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
         pc = pc + 20'h00137;
         step(r[0] | r[1], int'(r[4:2]) % NP, pc, r[23:12],
              r[7:5] == 3'd0, int'(r[10:8]) % NP, r[13:11] == 3'd0,
              "R3 R5 R6 R7 R8 random");
      end

      // reset again mid-run: R1
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      for (int i = 0; i < D; i++) m_v[i] = 0;
      m_ptr = 0;
      sweep("R1 re-reset empty");
      report_and_end();
   end
endmodule